// File: doc/BRIEF.md
# Packet Completion and Sense Reporter

This block turns the outcome of every packet command into the register image the host sees. A 16-bit completion code, delivered by the packet decoder or the transfer engine, is folded into a sense buffer, the error, count and status registers, and the interrupt request line. The low byte of the code is the sense key and the high byte is the additional sense code. A failed sector read can supply the logical block address that failed, and it is stored in the sense buffer next to the key.

Packet opcodes arrive here first. The block settles three cases itself. The first command after a device reset fails with a unit-attention code. Opcodes outside the configured set are refused. A request for sense data is served by capturing the sense bytes and starting a read of the clipped length. Every other opcode is passed on to the command decoder.

Top module: `pkt_sense_reporter`

## Requirements
- R1: After reset the error register reads 0x01, count 0x01, status 0x00, the interrupt is low and all sense bytes are zero.
- R2: Every applied completion code writes sense byte 0 to 0xF0, byte 2 to code bits 7:0 and byte 8 to code bits 15:8, one cycle after the strobe.
- R3: Every applied completion code sets the error register to {code[3:0], 4'b0000} and the count register to 3.
- R4: A non-zero code sets status to 0x51, raises the interrupt and pulses the return-to-idle output for one cycle.
- R5: A zero code clears only status bits 7 and 0, leaves the interrupt unchanged and gives no idle pulse.
- R6: While the unit-attention flag is set (armed by reset), the first packet whose opcode is not the request-sense opcode is not forwarded. It completes with the reset code (default 0x2906) and clears the flag. Request-sense packets leave the flag set.
- R7: A request-sense packet pulses the transfer-start output with length min(allocation, 10). It exposes on the read port the sense bytes as they were before the packet, then applies code 0. Read indices of 10 and above return 0.
- R8: A completion that carries the failing-address flag writes address bits 23:16, 15:8 and 7:0 into sense bytes 5, 6 and 7. Without the flag those bytes keep their value.
- R9: With the flag clear, an opcode outside the configured set completes with the invalid-command code (default 0x2005). A configured opcode is forwarded with its value one cycle later and changes no register.
- R10: The interrupt acknowledge clears the interrupt unless a non-zero code is applied in the same cycle, in which case the interrupt stays high.
- R11: The device-reset input restores the reset state of R1 and re-arms the unit-attention flag.
- R12: When a packet strobe and a completion strobe arrive in the same cycle, the packet is handled and the completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_reset | input | 1 | Device reset occurred; restore defaults |
| pkt_valid | input | 1 | A packet opcode is presented |
| pkt_op | input | 8 | Packet opcode |
| pkt_alloc | input | 8 | Allocation length byte of the packet |
| res_valid | input | 1 | Completion code strobe |
| res_code | input | 16 | Completion code (high byte additional code, low byte key) |
| res_lba_valid | input | 1 | Completion carries a failing address |
| res_lba | input | LBA_W | Failing logical block address |
| stat_ld | input | 1 | Task-file load of the status register |
| stat_ld_val | input | 8 | Value for the status load |
| irq_ack | input | 1 | Interrupt acknowledge |
| rd_idx | input | IDX_W | Index into captured sense bytes |
| err_reg | output | 8 | Error register |
| cnt_reg | output | 8 | Count register |
| stat_reg | output | 8 | Status register |
| irq | output | 1 | Interrupt request |
| go_idle | output | 1 | One-cycle return-to-idle pulse |
| xfer_start | output | 1 | Start of a sense-data read |
| xfer_len | output | 8 | Byte count of that read |
| rd_byte | output | 8 | Captured sense byte at rd_idx |
| fwd_valid | output | 1 | Opcode forwarded to the decoder |
| fwd_op | output | 8 | Forwarded opcode |

## Verification
The bench builds the block with a configured set of only three opcodes (0x00, 0x14, 0x30) and the default request-sense opcode 0x13. A full sweep of all 256 opcodes therefore covers both the forward and the refuse paths many times. Every low nibble of the completion code is swept, and so is every allocation length from 0 to 20, which puts both sides of the clip to 10 within reach. The failing-address width stays at 24 bits, so each address byte lands in its own sense position.

// File: rtl/sense_rpt_pkg.sv
package sense_rpt_pkg;
   localparam int          CODE_W        = 16;
   localparam logic [7:0]  SENSE_HDR     = 8'hF0;
   localparam logic [7:0]  STAT_FAIL     = 8'h51;
   localparam logic [7:0]  STAT_CLR_MASK = 8'h81;
   localparam logic [7:0]  CNT_DONE      = 8'h03;
   localparam logic [7:0]  ERR_RST       = 8'h01;
   localparam logic [7:0]  CNT_RST       = 8'h01;
   localparam logic [7:0]  STAT_RST      = 8'h00;
   localparam int          POS_KEY       = 2;
   localparam int          POS_ASC       = 8;
   localparam int          POS_LBA_HI    = 5;

   typedef struct packed {
      logic                valid;
      logic [CODE_W-1:0]   code;
   } apply_t;
endpackage

// File: rtl/op_classifier.sv
module op_classifier #(
   parameter int                    NUM_KNOWN = 11,
   parameter logic [NUM_KNOWN*8-1:0] KNOWN_OPS = 88'h00_10_11_12_14_15_20_30_40_70_71,
   parameter logic [7:0]            SENSE_OP  = 8'h13
) (
   input  logic [7:0] op,
   output logic       is_sense,
   output logic       is_known
);
   if (NUM_KNOWN < 1) begin : g_bad_cfg
      $error("op_classifier: NUM_KNOWN must be at least 1");
   end

   logic [NUM_KNOWN-1:0] hit;
   for (genvar g = 0; g < NUM_KNOWN; g++) begin : g_match
      assign hit[g] = (op == KNOWN_OPS[g*8 +: 8]);
   end

   assign is_sense = (op == SENSE_OP);
   assign is_known = |hit;
endmodule

// File: rtl/sense_store.sv
module sense_store
   import sense_rpt_pkg::*;
#(
   parameter int SENSE_LEN = 10,
   parameter int LBA_W     = 24,
   localparam int IDX_W    = $clog2(SENSE_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  apply_t            apply,
   input  logic              lba_wr,
   input  logic [LBA_W-1:0]  lba,
   input  logic              snap_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_byte
);
   if (SENSE_LEN < 10) begin : g_bad_len
      $error("sense_store: SENSE_LEN must cover byte 9");
   end
   if (LBA_W < 1 || LBA_W > 24) begin : g_bad_lba
      $error("sense_store: LBA_W must be 1..24");
   end

   logic [7:0]  live_q [SENSE_LEN];
   logic [7:0]  snap_q [SENSE_LEN];
   logic [23:0] lba24;

   assign lba24 = 24'(lba);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int i = 0; i < SENSE_LEN; i++) begin
            live_q[i] <= 8'h00;
            snap_q[i] <= 8'h00;
         end
      end else begin
         if (snap_en) begin
            for (int i = 0; i < SENSE_LEN; i++) snap_q[i] <= live_q[i];
         end
         if (apply.valid) begin
            live_q[0]       <= SENSE_HDR;
            live_q[POS_KEY] <= apply.code[7:0];
            live_q[POS_ASC] <= apply.code[15:8];
         end
         if (lba_wr) begin
            live_q[POS_LBA_HI]     <= lba24[23:16];
            live_q[POS_LBA_HI + 1] <= lba24[15:8];
            live_q[POS_LBA_HI + 2] <= lba24[7:0];
         end
      end
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int i = 0; i < SENSE_LEN; i++) begin
         if (int'(rd_idx) == i) rd_byte = snap_q[i];
      end
   end

   // R2: header and code bytes land one cycle after an applied code
   a_r2_code_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      (apply.valid && !clr) |=> (live_q[0] == SENSE_HDR) &&
                                (live_q[POS_KEY] == $past(apply.code[7:0])) &&
                                (live_q[POS_ASC] == $past(apply.code[15:8])));

   // R8: failing address low byte stored at byte 7
   a_r8_lba_low: assert property (@(posedge clk) disable iff (!rst_n)
      (lba_wr && !clr) |=> live_q[POS_LBA_HI + 2] == $past(lba24[7:0]));
endmodule

// File: rtl/task_regs.sv
module task_regs
   import sense_rpt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  apply_t     apply,
   input  logic       stat_ld,
   input  logic [7:0] stat_ld_val,
   input  logic       irq_ack,
   output logic [7:0] err_q,
   output logic [7:0] cnt_q,
   output logic [7:0] stat_q,
   output logic       irq_q,
   output logic       idle_q
);
   logic fail;
   assign fail = apply.valid && (apply.code != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         err_q  <= ERR_RST;
         cnt_q  <= CNT_RST;
         stat_q <= STAT_RST;
         irq_q  <= 1'b0;
         idle_q <= 1'b0;
      end else begin
         idle_q <= fail;
         if (fail)         irq_q <= 1'b1;
         else if (irq_ack) irq_q <= 1'b0;
         if (apply.valid) begin
            err_q <= {apply.code[3:0], 4'b0000};
            cnt_q <= CNT_DONE;
            if (fail) stat_q <= STAT_FAIL;
            else      stat_q <= stat_q & ~STAT_CLR_MASK;
         end else if (stat_ld) begin
            stat_q <= stat_ld_val;
         end
      end
   end

   // R3: error nibble and count after any applied code
   a_r3_err_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      (apply.valid && !clr) |=> (cnt_q == CNT_DONE) && (err_q[3:0] == 4'h0));

   // R4: non-zero code reports failure and interrupts
   a_r4_fail_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> (stat_q == STAT_FAIL) && irq_q && idle_q);

   // R5: zero code only clears the busy and check bits
   a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      (apply.valid && !fail && !clr) |=>
         (stat_q == ($past(stat_q) & ~STAT_CLR_MASK)) && !idle_q && $stable(irq_q));

   // R10: acknowledge without a new failure drops the request
   a_r10_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !fail) |=> !irq_q);
endmodule

// File: rtl/pkt_sense_reporter.sv
module pkt_sense_reporter
   import sense_rpt_pkg::*;
#(
   parameter int                     SENSE_LEN   = 10,
   parameter int                     LBA_W       = 24,
   parameter int                     NUM_KNOWN   = 11,
   parameter logic [NUM_KNOWN*8-1:0] KNOWN_OPS   = 88'h00_10_11_12_14_15_20_30_40_70_71,
   parameter logic [7:0]             SENSE_OP    = 8'h13,
   parameter logic [15:0]            RESET_CODE  = 16'h2906,
   parameter logic [15:0]            BADCMD_CODE = 16'h2005,
   localparam int                    IDX_W       = $clog2(SENSE_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_reset,
   input  logic              pkt_valid,
   input  logic [7:0]        pkt_op,
   input  logic [7:0]        pkt_alloc,
   input  logic              res_valid,
   input  logic [15:0]       res_code,
   input  logic              res_lba_valid,
   input  logic [LBA_W-1:0]  res_lba,
   input  logic              stat_ld,
   input  logic [7:0]        stat_ld_val,
   input  logic              irq_ack,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        err_reg,
   output logic [7:0]        cnt_reg,
   output logic [7:0]        stat_reg,
   output logic              irq,
   output logic              go_idle,
   output logic              xfer_start,
   output logic [7:0]        xfer_len,
   output logic [7:0]        rd_byte,
   output logic              fwd_valid,
   output logic [7:0]        fwd_op
);
   if (SENSE_LEN > 255) begin : g_bad_sense
      $error("pkt_sense_reporter: SENSE_LEN must fit the length byte");
   end

   localparam logic [7:0] SENSE_LEN8 = 8'(SENSE_LEN);

   logic   is_sense, is_known;
   logic   ua_q;
   apply_t apply;
   logic   lba_wr, snap_en, fwd_d, start_d, ua_clr;
   logic [7:0] len_d;

   op_classifier #(
      .NUM_KNOWN (NUM_KNOWN),
      .KNOWN_OPS (KNOWN_OPS),
      .SENSE_OP  (SENSE_OP)
   ) cls_i (
      .op       (pkt_op),
      .is_sense (is_sense),
      .is_known (is_known)
   );

   always_comb begin
      apply   = '{valid: 1'b0, code: '0};
      lba_wr  = 1'b0;
      snap_en = 1'b0;
      fwd_d   = 1'b0;
      start_d = 1'b0;
      ua_clr  = 1'b0;
      len_d   = (pkt_alloc > SENSE_LEN8) ? SENSE_LEN8 : pkt_alloc;
      if (pkt_valid) begin
         if (is_sense) begin
            snap_en     = 1'b1;
            start_d     = 1'b1;
            apply.valid = 1'b1;
         end else if (ua_q) begin
            ua_clr      = 1'b1;
            apply.valid = 1'b1;
            apply.code  = RESET_CODE;
         end else if (!is_known) begin
            apply.valid = 1'b1;
            apply.code  = BADCMD_CODE;
         end else begin
            fwd_d = 1'b1;
         end
      end else if (res_valid) begin
         apply.valid = 1'b1;
         apply.code  = res_code;
         lba_wr      = res_lba_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || dev_reset) begin
         ua_q       <= 1'b1;
         fwd_valid  <= 1'b0;
         fwd_op     <= 8'h00;
         xfer_start <= 1'b0;
         xfer_len   <= 8'h00;
      end else begin
         if (ua_clr) ua_q <= 1'b0;
         fwd_valid  <= fwd_d;
         fwd_op     <= fwd_d ? pkt_op : fwd_op;
         xfer_start <= start_d;
         xfer_len   <= start_d ? len_d : xfer_len;
      end
   end

   sense_store #(
      .SENSE_LEN (SENSE_LEN),
      .LBA_W     (LBA_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (dev_reset),
      .apply   (apply),
      .lba_wr  (lba_wr),
      .lba     (res_lba),
      .snap_en (snap_en),
      .rd_idx  (rd_idx),
      .rd_byte (rd_byte)
   );

   task_regs regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (dev_reset),
      .apply       (apply),
      .stat_ld     (stat_ld),
      .stat_ld_val (stat_ld_val),
      .irq_ack     (irq_ack),
      .err_q       (err_reg),
      .cnt_q       (cnt_reg),
      .stat_q      (stat_reg),
      .irq_q       (irq),
      .idle_q      (go_idle)
   );

   // R6: a non-sense packet under unit attention clears the flag and is not forwarded
   a_r6_unit_attn: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && ua_q && !is_sense && !dev_reset) |=> !ua_q && !fwd_valid);

   // R7: transfer length never exceeds the sense buffer
   a_r7_len_clip: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> xfer_len <= SENSE_LEN8);

   // R9: a forwarded opcode never coincides with a sense transfer or idle pulse
   a_r9_fwd_excl: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !xfer_start && !go_idle);
endmodule

// File: tb/pkt_sense_reporter_tb_top.sv
module pkt_sense_reporter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_reset = 0, pkt_valid = 0, res_valid = 0, res_lba_valid = 0;
   logic        stat_ld = 0, irq_ack = 0;
   logic [7:0]  pkt_op = 0, pkt_alloc = 0, stat_ld_val = 0;
   logic [15:0] res_code = 0;
   logic [23:0] res_lba = 0;
   logic [IDX_W-1:0] rd_idx = 0;
   logic [7:0]  err_reg, cnt_reg, stat_reg, xfer_len, rd_byte, fwd_op;
   logic        irq, go_idle, xfer_start, fwd_valid;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_sense [10];
   logic [7:0] m_err, m_cnt, m_stat;
   logic       m_irq, m_idle;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_sense_reporter #(
      .NUM_KNOWN (3),
      .KNOWN_OPS (24'h00_14_30)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
      .pkt_valid(pkt_valid), .pkt_op(pkt_op), .pkt_alloc(pkt_alloc),
      .res_valid(res_valid), .res_code(res_code),
      .res_lba_valid(res_lba_valid), .res_lba(res_lba),
      .stat_ld(stat_ld), .stat_ld_val(stat_ld_val), .irq_ack(irq_ack),
      .rd_idx(rd_idx),
      .err_reg(err_reg), .cnt_reg(cnt_reg), .stat_reg(stat_reg),
      .irq(irq), .go_idle(go_idle), .xfer_start(xfer_start),
      .xfer_len(xfer_len), .rd_byte(rd_byte),
      .fwd_valid(fwd_valid), .fwd_op(fwd_op)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      dev_reset = 0; pkt_valid = 0; res_valid = 0; res_lba_valid = 0;
      stat_ld = 0; irq_ack = 0;
   endtask

   task automatic m_reset();
      for (int i = 0; i < 10; i++) m_sense[i] = 8'h00;
      m_err = 8'h01; m_cnt = 8'h01; m_stat = 8'h00; m_irq = 1'b0; m_idle = 1'b0;
   endtask

   task automatic m_apply(input logic [15:0] code);
      m_sense[0] = 8'hF0;
      m_sense[2] = code[7:0];
      m_sense[8] = code[15:8];
      m_err = {code[3:0], 4'h0};
      m_cnt = 8'h03;
      if (code != 16'h0) begin
         m_stat = 8'h51; m_irq = 1'b1; m_idle = 1'b1;
      end else begin
         m_stat = m_stat & 8'h7E; m_idle = 1'b0;
      end
   endtask

   task automatic chk_regs(input string tag);
      chk({tag, " err"},  err_reg,  m_err);
      chk({tag, " cnt"},  cnt_reg,  m_cnt);
      chk({tag, " stat"}, stat_reg, m_stat);
      chk({tag, " irq"},  irq,      m_irq);
      chk({tag, " idle"}, go_idle,  m_idle);
   endtask

   // request-sense: checks length and captured bytes (R7)
   task automatic do_sense(input string tag, input logic [7:0] alloc, input bit read_all);
      logic [7:0] snap [10];
      for (int i = 0; i < 10; i++) snap[i] = m_sense[i];
      pkt_valid = 1; pkt_op = 8'h13; pkt_alloc = alloc;
      step();
      m_apply(16'h0);
      chk({tag, " R7 start"}, xfer_start, 1'b1);
      chk({tag, " R7 len"}, xfer_len, (alloc > 10) ? 8'd10 : alloc);
      chk_regs({tag, " R7 regs"});
      if (read_all) begin
         for (int i = 0; i < 10; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            chk($sformatf("%s R7 byte%0d", tag, i), rd_byte, snap[i]);
         end
         rd_idx = 4'd12;
         #1;
         chk({tag, " R7 idx12"}, rd_byte, 8'h00);
      end
   endtask

   task automatic send_op(input logic [7:0] op);
      pkt_valid = 1; pkt_op = op; pkt_alloc = 8'h00;
      step();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_reset();
      @(negedge clk);
      step(); step();
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk_regs("R1 reset");
      chk("R1 fwd", fwd_valid, 1'b0);
      do_sense("R1 sense", 8'd10, 1);

      // R6 sense does not clear the flag; first other packet fails with reset code
      do_sense("R6 sense keeps flag", 8'd4, 0);
      send_op(8'h00);
      m_apply(16'h2906);
      chk("R6 no fwd", fwd_valid, 1'b0);
      chk_regs("R6 ua");
      send_op(8'h00);
      m_idle = 0;
      chk("R6 second fwd", fwd_valid, 1'b1);
      chk("R9 fwd op", fwd_op, 8'h00);
      chk_regs("R9 fwd unchanged");
      do_sense("R6 sense bytes", 8'd10, 1);

      // R10 ack and same-cycle set
      irq_ack = 1; step(); m_irq = 0; m_idle = 0;
      chk("R10 ack", irq, 1'b0);
      res_valid = 1; res_code = 16'h0402; irq_ack = 1; step();
      m_apply(16'h0402);
      chk("R10 set wins", irq, 1'b1);

      // R3/R4 sweep of every low nibble, plus R2 bytes
      for (int n = 0; n < 16; n++) begin
         logic [15:0] c;
         c = {8'(8'h30 + n), 8'(8'h40 + n)};
         res_valid = 1; res_code = c; step();
         m_apply(c);
         chk_regs($sformatf("R3 R4 nib%0d", n));
         if (n % 4 == 0) do_sense($sformatf("R2 nib%0d", n), 8'd10, 1);
      end

      // R5 zero code clears only bits 7 and 0
      irq_ack = 1; step(); m_irq = 0; m_idle = 0;
      stat_ld = 1; stat_ld_val = 8'hD9; step(); m_stat = 8'hD9;
      chk("R5 load", stat_reg, 8'hD9);
      res_valid = 1; res_code = 16'h0000; step();
      m_apply(16'h0000);
      chk_regs("R5 zero");
      chk("R5 stat", stat_reg, 8'h58);

      // R8 failing address bytes
      res_valid = 1; res_code = 16'h1103; res_lba_valid = 1; res_lba = 24'hABCDEF; step();
      m_apply(16'h1103);
      m_sense[5] = 8'hAB; m_sense[6] = 8'hCD; m_sense[7] = 8'hEF;
      chk_regs("R8 regs");
      do_sense("R8 lba", 8'd10, 1);
      res_valid = 1; res_code = 16'h0206; res_lba = 24'h123456; step();
      m_apply(16'h0206);
      do_sense("R8 no flag keeps", 8'd10, 1);

      // R7 allocation sweep
      for (int a = 0; a <= 20; a++) do_sense($sformatf("R7 alloc%0d", a), 8'(a), 0);

      // R9 opcode sweep
      for (int op = 0; op < 256; op++) begin
         if (op == 8'h13) continue;
         send_op(8'(op));
         if (op == 8'h00 || op == 8'h14 || op == 8'h30) begin
            m_idle = 0;
            chk($sformatf("R9 fwd %0h", op), fwd_valid, 1'b1);
            chk($sformatf("R9 fwdop %0h", op), fwd_op, 8'(op));
         end else begin
            m_apply(16'h2005);
            chk($sformatf("R9 nofwd %0h", op), fwd_valid, 1'b0);
         end
         chk_regs($sformatf("R9 op%0h", op));
      end

      // R12 packet wins over completion
      do_sense("R12 pre", 8'd1, 0);
      pkt_valid = 1; pkt_op = 8'h14; res_valid = 1; res_code = 16'h0707; step();
      m_idle = 0;
      chk("R12 fwd", fwd_valid, 1'b1);
      chk_regs("R12 dropped");

      // R11 device reset
      res_valid = 1; res_code = 16'h0101; step();
      dev_reset = 1; step();
      m_reset();
      chk_regs("R11 restore");
      do_sense("R11 sense zero", 8'd10, 1);
      send_op(8'h30);
      m_apply(16'h2906);
      chk("R11 ua rearmed", fwd_valid, 1'b0);
      chk_regs("R11 ua code");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule